// File: doc/BRIEF.md
# Timer Port Pin Direction Controller

This block sits between a timer peripheral and an eight-pin general-purpose port. Software sets a per-pin direction register and a port data register over a small register bus. For every pin the block decides whether the pad is driven and with which value. The decision uses the stored direction bit and whether the timer channel mapped to that pin is running an output compare. An active compare channel takes the pin over as an output without touching the stored bit. Once the compare channel is released, the stored bit is in control again. Capture channels never take a pin over.

The block also decides from the device operating mode whether the timer counter may advance. It applies the same decision to the pulse accumulator, and from that it produces a one-cycle enable that recurs every 64 cycles for the accumulator's gated clock. The counter, the compare and capture logic and the accumulator datapath are outside the block. They consume `cnt_run_o`, `pa_run_o` and `pa_div64_en_o`.

Top module: `tmr_pin_dir_ctrl`

## Requirements
- R1: The direction register is 8 bits, written and read at bus address 0. A bit value of 1 makes its pin an output and 0 makes it an input, so with no compare channel active `pin_oe_o` equals the register.
- R2: After reset the direction register and the port data register read 0, `pin_oe_o` is 0, and `cnt_run_o`, `pa_run_o` and `pa_div64_en_o` are 0.
- R3: Both registers can be written and read back in every operating mode, stop mode included, whatever the timer enables are.
- R4: While `oc_en_i[i]` is 1, `pin_oe_o[i]` is 1 and `pin_o[i]` equals `oc_val_i[i]`. The stored direction bit keeps its value and reads back unchanged.
- R5: When `oc_en_i[i]` returns to 0, `pin_oe_o[i]` again equals stored direction bit i in the same cycle.
- R6: `ic_en_i` has no effect on `pin_oe_o`, `pin_o` or read data.
- R7: Mode encoding on `mode_i`: 00 normal, 01 wait, 10 debug, 11 stop. In stop mode `cnt_run_o` is 0 from the cycle after the mode is seen.
- R8: In debug mode `cnt_run_o` is 1 one cycle later when `tmr_en_i` is 1 and `dbg_stop_i` is 0. It is 0 when `dbg_stop_i` is 1.
- R9: In wait mode `cnt_run_o` is 1 one cycle later when `tmr_en_i` is 1 and `wait_stop_i` is 0. It is 0 when `wait_stop_i` is 1.
- R10: In normal mode `cnt_run_o` follows `tmr_en_i` one cycle later. A `tmr_en_i` of 0 stops the counter in every mode.
- R11: `pa_run_o` is 1 only when `pa_en_i` was 1 and the counter run condition held in the previous cycle. With `pa_en_i` at 0 both `pa_run_o` and `pa_div64_en_o` stay 0.
- R12: While `pa_run_o` stays 1, `pa_div64_en_o` is a one-cycle pulse that occurs exactly once in every 64 consecutive cycles.
- R13: The port data register is at bus address 1 and drives `pin_o[i]` for pins without an active compare channel. A read of address 1 returns, per bit, the register bit if the pin is driven and otherwise the pin level after a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe, valid with select |
| bus_addr_i | input | 1 | 0 = direction register, 1 = port data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| oc_en_i | input | 8 | Output-compare channel enable per pin |
| oc_val_i | input | 8 | Output-compare drive level per pin |
| ic_en_i | input | 8 | Input-capture channel enable per pin |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| mode_i | input | 2 | Operating mode |
| tmr_en_i | input | 1 | Timer enable |
| wait_stop_i | input | 1 | Stop counter in wait mode |
| dbg_stop_i | input | 1 | Stop counter in debug mode |
| pa_en_i | input | 1 | Pulse accumulator enable |
| cnt_run_o | output | 1 | Timer counter may advance |
| pa_run_o | output | 1 | Pulse accumulator may operate |
| pa_div64_en_o | output | 1 | Divide-by-64 gated clock enable pulse |

## Verification
The bench sets a direction pattern, lays compare enables over part of it and reads the direction register back. A design that wrote the override into the stored bits would read back the wrong value and keep driving after the compare channel is released. It raises every capture enable over a mixed direction pattern to catch a design that treats capture like compare. Each mode is paired with its own stop bit and with the timer enable dropped, which exposes a gate that looks at the wrong control bit or lets a mode stop bit override the timer enable. The divide-by-64 enable is counted over an exact multiple of its period, so a prescaler that is off by one or that pulses while the accumulator is disabled gives a wrong count.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_WAIT  = 2'b01,
        MODE_DEBUG = 2'b10,
        MODE_STOP  = 2'b11
    } op_mode_e;

    localparam int unsigned ADDR_DIR = 0;
    localparam int unsigned ADDR_DAT = 1;

endpackage

// File: rtl/tpd_dir_reg.sv
module tpd_dir_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_dir_i,
    input  logic         wr_dat_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] dat_o
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dat;
    } regs_s;

    regs_s regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_dir_i) begin
            regs_d.dir = wdata_i;
        end
        if (wr_dat_i) begin
            regs_d.dat = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_o = regs_q.dir;
    assign dat_o = regs_q.dat;

endmodule

// File: rtl/tpd_pin_sync.sv
module tpd_pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_sync_o
);

    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            sync_d[k] = sync_q[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/tpd_pin_resolve.sv
module tpd_pin_resolve #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] dat_i,
    input  logic [W-1:0] oc_en_i,
    input  logic [W-1:0] oc_val_i,
    input  logic [W-1:0] pin_sync_i,
    output logic [W-1:0] pin_oe_o,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] port_rd_o
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic forced;
        assign forced       = oc_en_i[i];
        assign pin_oe_o[i]  = forced | dir_i[i];
        assign pin_o[i]     = forced ? oc_val_i[i] : dat_i[i];
        assign port_rd_o[i] = pin_oe_o[i] ? dat_i[i] : pin_sync_i[i];
    end

endmodule

// File: rtl/tpd_mode_gate.sv
module tpd_mode_gate
    import tpd_pkg::*;
#(
    parameter int unsigned PRE_W = 6
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  op_mode_e mode_i,
    input  logic     tmr_en_i,
    input  logic     wait_stop_i,
    input  logic     dbg_stop_i,
    input  logic     pa_en_i,
    output logic     cnt_run_o,
    output logic     pa_run_o,
    output logic     div_tick_o
);

    typedef struct packed {
        logic             cnt_run;
        logic             pa_run;
        logic [PRE_W-1:0] pre;
    } gate_s;

    gate_s gate_d, gate_q;
    logic  mode_ok;

    always_comb begin
        unique case (mode_i)
            MODE_STOP:  mode_ok = 1'b0;
            MODE_DEBUG: mode_ok = !dbg_stop_i;
            MODE_WAIT:  mode_ok = !wait_stop_i;
            default:    mode_ok = 1'b1;
        endcase
        gate_d.cnt_run = tmr_en_i && mode_ok;
        gate_d.pa_run  = pa_en_i && gate_d.cnt_run;
        gate_d.pre     = gate_q.pa_run ? gate_q.pre + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign cnt_run_o  = gate_q.cnt_run;
    assign pa_run_o   = gate_q.pa_run;
    assign div_tick_o = gate_q.pa_run && (&gate_q.pre);

endmodule

// File: rtl/tmr_pin_dir_ctrl.sv
module tmr_pin_dir_ctrl
    import tpd_pkg::*;
#(
    parameter int unsigned PINS        = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_LOG2    = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            bus_sel_i,
    input  logic            bus_we_i,
    input  logic            bus_addr_i,
    input  logic [PINS-1:0] bus_wdata_i,
    output logic [PINS-1:0] bus_rdata_o,
    input  logic [PINS-1:0] oc_en_i,
    input  logic [PINS-1:0] oc_val_i,
    input  logic [PINS-1:0] ic_en_i,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] pin_o,
    output logic [PINS-1:0] pin_oe_o,
    input  logic [1:0]      mode_i,
    input  logic            tmr_en_i,
    input  logic            wait_stop_i,
    input  logic            dbg_stop_i,
    input  logic            pa_en_i,
    output logic            cnt_run_o,
    output logic            pa_run_o,
    output logic            pa_div64_en_o
);

    logic            wr_dir, wr_dat;
    logic [PINS-1:0] dir_q, dat_q, pin_sync, port_rd;
    logic            ic_unused;

    // Capture channels deliberately leave pin direction alone.
    assign ic_unused = ^ic_en_i;

    assign wr_dir = bus_sel_i && bus_we_i && (bus_addr_i == 1'(ADDR_DIR));
    assign wr_dat = bus_sel_i && bus_we_i && (bus_addr_i == 1'(ADDR_DAT));

    tpd_dir_reg #(.W(PINS)) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_dir_i (wr_dir),
        .wr_dat_i (wr_dat),
        .wdata_i  (bus_wdata_i),
        .dir_o    (dir_q),
        .dat_o    (dat_q)
    );

    tpd_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i),
        .pin_sync_o (pin_sync)
    );

    tpd_pin_resolve #(.W(PINS)) i_resolve (
        .dir_i      (dir_q),
        .dat_i      (dat_q),
        .oc_en_i    (oc_en_i),
        .oc_val_i   (oc_val_i),
        .pin_sync_i (pin_sync),
        .pin_oe_o   (pin_oe_o),
        .pin_o      (pin_o),
        .port_rd_o  (port_rd)
    );

    tpd_mode_gate #(.PRE_W(DIV_LOG2)) i_gate (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (op_mode_e'(mode_i)),
        .tmr_en_i    (tmr_en_i),
        .wait_stop_i (wait_stop_i),
        .dbg_stop_i  (dbg_stop_i),
        .pa_en_i     (pa_en_i),
        .cnt_run_o   (cnt_run_o),
        .pa_run_o    (pa_run_o),
        .div_tick_o  (pa_div64_en_o)
    );

    assign bus_rdata_o = (bus_addr_i == 1'(ADDR_DIR)) ? dir_q : port_rd;

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker
    import tpd_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            bus_sel_i,
    input logic            bus_we_i,
    input logic            bus_addr_i,
    input logic [PINS-1:0] oc_en_i,
    input logic [PINS-1:0] oc_val_i,
    input logic [PINS-1:0] pin_o,
    input logic [PINS-1:0] pin_oe_o,
    input logic [1:0]      mode_i,
    input logic            tmr_en_i,
    input logic            dbg_stop_i,
    input logic            pa_en_i,
    input logic            cnt_run_o,
    input logic            pa_run_o,
    input logic            pa_div64_en_o
);

    logic dir_wr;
    assign dir_wr = bus_sel_i && bus_we_i && (bus_addr_i == 1'(ADDR_DIR));

    p_oc_forces_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oc_en_i & ~pin_oe_o) == '0);

    p_oc_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oc_en_i & (pin_o ^ oc_val_i)) == '0);

    p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $stable(oc_en_i) && !$past(dir_wr)) |-> $stable(pin_oe_o));

    p_stop_halts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(mode_i == MODE_STOP) |-> !cnt_run_o);

    p_debug_runs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni && mode_i == MODE_DEBUG && tmr_en_i && !dbg_stop_i) |-> cnt_run_o);

    p_ten_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!tmr_en_i) |-> !cnt_run_o);

    p_pa_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!pa_en_i) |-> (!pa_run_o && !pa_div64_en_o));

    p_tick_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pa_div64_en_o |=> !pa_div64_en_o);

    p_tick_needs_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pa_div64_en_o |-> pa_run_o);

endmodule

bind tmr_pin_dir_ctrl tpd_checker #(.PINS(PINS)) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_sel_i     (bus_sel_i),
    .bus_we_i      (bus_we_i),
    .bus_addr_i    (bus_addr_i),
    .oc_en_i       (oc_en_i),
    .oc_val_i      (oc_val_i),
    .pin_o         (pin_o),
    .pin_oe_o      (pin_oe_o),
    .mode_i        (mode_i),
    .tmr_en_i      (tmr_en_i),
    .dbg_stop_i    (dbg_stop_i),
    .pa_en_i       (pa_en_i),
    .cnt_run_o     (cnt_run_o),
    .pa_run_o      (pa_run_o),
    .pa_div64_en_o (pa_div64_en_o)
);

// File: tb/test_tmr_pin_dir_ctrl.sv
module test_tmr_pin_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, we = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] oc_en = '0, oc_val = '0, ic_en = '0, pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [1:0] mode = 2'b00;
    logic       tmr_en = 1'b0, wait_stop = 1'b0, dbg_stop = 1'b0, pa_en = 1'b0;
    logic       cnt_run, pa_run, div_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tmr_pin_dir_ctrl i_tmr_pin_dir_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .oc_en_i(oc_en), .oc_val_i(oc_val), .ic_en_i(ic_en),
        .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
        .mode_i(mode), .tmr_en_i(tmr_en), .wait_stop_i(wait_stop),
        .dbg_stop_i(dbg_stop), .pa_en_i(pa_en),
        .cnt_run_o(cnt_run), .pa_run_o(pa_run), .pa_div64_en_o(div_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_mode(input logic [1:0] m, input logic ten, input logic ws, input logic ds);
        @(negedge clk);
        mode = m; tmr_en = ten; wait_stop = ws; dbg_stop = ds;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(1'b0, d);
        chk("R2 dir reset", d, 8'h00);
        chk("R2 oe reset", pin_oe, 8'h00);
        chk("R2 run reset", {cnt_run, pa_run, div_en}, 3'b000);
        bus_read(1'b1, d);
        chk("R2 data reset", d, 8'h00);
    endtask

    task automatic t_dir_rw();
        logic [7:0] d;
        bus_write(1'b0, 8'hA5);
        bus_read(1'b0, d);
        chk("R1 dir readback", d, 8'hA5);
        chk("R1 oe follows dir", pin_oe, 8'hA5);
    endtask

    task automatic t_oc_override();
        logic [7:0] d;
        bus_write(1'b0, 8'h0F);
        @(negedge clk);
        oc_en = 8'hF0; oc_val = 8'hA0;
        #1;
        chk("R4 oc forces oe", pin_oe, 8'hFF);
        chk("R4 oc drives value", pin_out & 8'hF0, 8'hA0);
        bus_read(1'b0, d);
        chk("R4 stored dir unchanged", d, 8'h0F);
        @(negedge clk);
        oc_en = 8'h00;
        #1;
        chk("R5 dir restored", pin_oe, 8'h0F);
    endtask

    task automatic t_ic_ignored();
        logic [7:0] d;
        bus_write(1'b1, 8'h96);
        bus_write(1'b0, 8'h3C);
        @(negedge clk);
        ic_en = 8'hFF;
        #1;
        chk("R6 ic no oe effect", pin_oe, 8'h3C);
        chk("R6 ic no value effect", pin_out, 8'h96);
        bus_read(1'b0, d);
        chk("R6 ic no dir effect", d, 8'h3C);
        @(negedge clk);
        ic_en = 8'h00;
    endtask

    task automatic t_port_data();
        logic [7:0] d;
        bus_write(1'b1, 8'h5A);
        bus_write(1'b0, 8'hF0);
        @(negedge clk);
        pin_in = 8'h0F;
        repeat (3) @(negedge clk);
        bus_read(1'b1, d);
        chk("R13 mixed port read", d, 8'h5F);
        chk("R13 pin out from data", pin_out, 8'h5A);
        @(negedge clk);
        oc_en = 8'h01;
        #1;
        bus_read(1'b1, d);
        chk("R13 forced pin reads data", d, 8'h5E);
        @(negedge clk);
        oc_en = 8'h00;
    endtask

    task automatic t_modes();
        set_mode(2'b00, 1'b1, 1'b0, 1'b0);
        chk("R10 normal runs", cnt_run, 1'b1);
        set_mode(2'b00, 1'b0, 1'b0, 1'b0);
        chk("R10 normal ten off", cnt_run, 1'b0);
        set_mode(2'b01, 1'b1, 1'b0, 1'b1);
        chk("R9 wait runs", cnt_run, 1'b1);
        set_mode(2'b01, 1'b1, 1'b1, 1'b0);
        chk("R9 wait stop bit", cnt_run, 1'b0);
        set_mode(2'b10, 1'b1, 1'b1, 1'b0);
        chk("R8 debug runs", cnt_run, 1'b1);
        set_mode(2'b10, 1'b1, 1'b0, 1'b1);
        chk("R8 debug stop bit", cnt_run, 1'b0);
        set_mode(2'b10, 1'b0, 1'b0, 1'b0);
        chk("R10 debug ten off", cnt_run, 1'b0);
        set_mode(2'b11, 1'b1, 1'b0, 1'b0);
        chk("R7 stop halts", cnt_run, 1'b0);
    endtask

    task automatic t_stop_access();
        logic [7:0] d;
        set_mode(2'b11, 1'b0, 1'b1, 1'b1);
        bus_write(1'b0, 8'h81);
        bus_read(1'b0, d);
        chk("R3 dir in stop", d, 8'h81);
        bus_write(1'b1, 8'h7E);
        bus_write(1'b0, 8'hFF);
        bus_read(1'b1, d);
        chk("R3 data in stop", d, 8'h7E);
    endtask

    task automatic t_pulse_acc();
        int ticks;
        set_mode(2'b00, 1'b1, 1'b0, 1'b0);
        ticks = 0;
        for (int k = 0; k < 130; k++) begin
            @(negedge clk);
            ticks += int'(div_en) + int'(pa_run);
        end
        chk("R11 pa disabled", ticks, 0);
        @(negedge clk);
        pa_en = 1'b1;
        @(negedge clk);
        chk("R11 pa runs", pa_run, 1'b1);
        repeat (10) @(negedge clk);
        ticks = 0;
        for (int k = 0; k < 192; k++) begin
            @(negedge clk);
            ticks += int'(div_en);
        end
        chk("R12 tick count", ticks, 3);
        set_mode(2'b11, 1'b1, 1'b0, 1'b0);
        chk("R11 pa stops in stop", pa_run, 1'b0);
        @(negedge clk);
        pa_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_rw();
        t_oc_override();
        t_ic_ignored();
        t_port_data();
        t_modes();
        t_stop_access();
        t_pulse_acc();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule